// File: doc/BRIEF.md
# Emulated Parallel Printer Port

This block is a host-side parallel printer port on a byte-wide I/O bus. Behind the port sits a small logic model of a printer, so the host-visible strobe, busy and acknowledge handshake completes without any external device. The block decodes an eight-byte address window into three registers: a byte register for data, a read-only printer-condition byte and a port-command byte. The host writes a byte to the data register and pulses the strobe bit in the command register. The block then emits that byte on a one-cycle valid/data stream and makes busy and acknowledge step through their sequence.

The printer model is a three-state machine. In the Ready state the condition byte is 0xD8. In Taken it is 0x58, because busy has been cleared. In AckLow it is 0x18, because acknowledge has been cleared as well. There are four named transitions. Accept goes from Ready to Taken on a strobe-high command write. AckDrop goes from Taken to AckLow on a condition read. Release goes from AckLow back to Ready on a condition read. Init goes from any state to Ready on a command write with the init bit low. Accept and Init are driven by command writes. AckDrop and Release happen only when the host reads the condition register while busy is clear and the stored strobe bit is 0. An interrupt request line shows an interrupt-pending flag as a level. A command write can set this flag, and every condition read clears it.

Top module: `lpt_printer_port`

## Requirements
- R1: After synchronous reset, data reads 0x00, the condition byte reads 0xD8, the command byte reads 0x0C, and irq and out_valid are 0.
- R2: Only address bits [2:0] are decoded. Offset 0 is data, offset 1 is the read-only condition byte and offset 2 is command. A read at any other offset returns 0xFF. A write to offset 1 or to offsets 3 to 7 changes no register.
- R3: A data write only stores the byte. Data and command reads return the stored values and have no side effects.
- R4: A command write with bit 2 (init, active low) at 0 puts the condition byte back to 0xD8, which is the Ready state.
- R5: A command write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears condition bit 7 (busy, active low).
- R6: The write in R5 emits the stored data byte only if the previously stored strobe bit was 0. The byte appears as a single-cycle out_valid pulse in the cycle after the write. No other access produces a pulse.
- R7: A command write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 raises irq from the next cycle, but only if the previously stored command byte had bit 4 (interrupt enable) set. The newly written bit 4 is not used for this decision.
- R8: A condition read returns the byte as it was before the read, and irq is 0 from the next cycle.
- R9: On a condition read with busy 0 and stored strobe 0, the block steps to the next state. If acknowledge (bit 6) is 1, it is cleared, giving 0x18. If acknowledge is 0, acknowledge and busy are both set, giving 0xD8. In every other case the read leaves the condition byte unchanged.
- R10: A command write with init 1 and select 0 leaves the condition byte and irq unchanged and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | I/O address; only bits [2:0] are decoded |
| bus_wr | input | 1 | Single-cycle write strobe; takes priority if asserted with bus_rd |
| bus_rd | input | 1 | Single-cycle read strobe; has no side effect when bus_wr is also asserted |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| out_valid | output | 1 | One-cycle pulse when a byte is emitted |
| out_data | output | 8 | Emitted byte, qualified by out_valid |
| irq | output | 1 | Interrupt request level |

## Verification
The bench targets the edge cases of the stored strobe bit. One test re-writes the command byte with strobe still high. Another raises strobe while select is low and then raises it again with select high. A design that looks only at the new value would emit a duplicate byte or a byte from a rejected write. The bench checks that the acknowledge sequence steps only on condition reads with strobe released, and never on data or command reads. A model that advanced on every access, or ignored strobe, would show 0x18 or 0xD8 too early. The interrupt tests pair an old enable bit with a new value that has enable clear, and the reverse. A design that checked the new value would raise irq at the wrong time.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_COND = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CMD  = 3'd2;

    // condition byte bit positions
    localparam int CB_BUSY_N  = 7;
    localparam int CB_ACK     = 6;
    localparam int CB_PAPER   = 5;
    localparam int CB_ONLINE  = 4;
    localparam int CB_ERROR_N = 3;

    // command byte bit positions
    localparam int CM_IRQ_EN = 4;
    localparam int CM_SELECT = 3;
    localparam int CM_INIT_N = 2;
    localparam int CM_STROBE = 0;

    localparam logic [BYTE_W-1:0] COND_READY = 8'hD8;
    localparam logic [BYTE_W-1:0] CMD_RESET  = 8'h0C;
    localparam logic [BYTE_W-1:0] OPEN_READ  = 8'hFF;

    typedef enum logic [1:0] {
        HS_READY   = 2'd0,
        HS_TAKEN   = 2'd1,
        HS_ACK_LOW = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic data_wr;
        logic cmd_wr;
        logic data_rd;
        logic cond_rd;
        logic cmd_rd;
    } bus_ev_t;
endpackage

// File: rtl/lpt_bus_decode.sv
module lpt_bus_decode
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] data_q,
    input  logic [BYTE_W-1:0] cond_byte,
    input  logic [BYTE_W-1:0] cmd_q,
    output bus_ev_t           ev,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic [OFS_W-1:0] ofs;
    logic             rd_only;

    assign ofs     = bus_addr[OFS_W-1:0];
    assign rd_only = bus_rd && !bus_wr;

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^bus_addr[ADDR_W-1:OFS_W];
        end
    endgenerate

    always_comb begin
        ev         = '0;
        ev.data_wr = bus_wr  && (ofs == OFS_DATA);
        ev.cmd_wr  = bus_wr  && (ofs == OFS_CMD);
        ev.data_rd = rd_only && (ofs == OFS_DATA);
        ev.cond_rd = rd_only && (ofs == OFS_COND);
        ev.cmd_rd  = rd_only && (ofs == OFS_CMD);
    end

    always_comb begin
        unique case (ofs)
            OFS_DATA: bus_rdata = data_q;
            OFS_COND: bus_rdata = cond_byte;
            OFS_CMD:  bus_rdata = cmd_q;
            default:  bus_rdata = OPEN_READ;
        endcase
    end

    AST_SINGLE_EVENT: assert final ($onehot0(ev)) else $error("decode raised two events"); // R2
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] cmd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            cmd_q  <= CMD_RESET;
        end else begin
            if (ev.data_wr) data_q <= bus_wdata;
            if (ev.cmd_wr)  cmd_q  <= bus_wdata;
        end
    end

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ev.data_wr |=> $stable(data_q)) else $error("data changed without write"); // R3
    AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ev.cmd_wr |=> $stable(cmd_q)) else $error("command changed without write"); // R3
endmodule

// File: rtl/lpt_printer_fsm.sv
module lpt_printer_fsm
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              old_strobe,
    input  logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] cond_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    hs_state_e state_q, state_d;
    logic      init_wr, accept_wr, step_rd, emit;

    assign init_wr   = ev.cmd_wr && !bus_wdata[CM_INIT_N];
    assign accept_wr = ev.cmd_wr && bus_wdata[CM_INIT_N] && bus_wdata[CM_SELECT]
                       && bus_wdata[CM_STROBE];
    assign step_rd   = ev.cond_rd && !old_strobe;
    assign emit      = accept_wr && !old_strobe;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_READY;
        else     state_q <= state_d;
    end

    // transitions: Init, Accept, AckDrop, Release
    always_comb begin
        state_d = state_q;
        if (init_wr) begin
            state_d = HS_READY;
        end else begin
            unique case (state_q)
                HS_READY:   if (accept_wr) state_d = HS_TAKEN;
                HS_TAKEN:   if (step_rd)   state_d = HS_ACK_LOW;
                HS_ACK_LOW: if (step_rd)   state_d = HS_READY;
                default:                   state_d = HS_READY;
            endcase
        end
    end

    // outputs
    always_comb begin
        cond_byte             = '0;
        cond_byte[CB_ONLINE]  = 1'b1;
        cond_byte[CB_ERROR_N] = 1'b1;
        cond_byte[CB_PAPER]   = 1'b0;
        unique case (state_q)
            HS_READY:   begin cond_byte[CB_BUSY_N] = 1'b1; cond_byte[CB_ACK] = 1'b1; end
            HS_TAKEN:   begin cond_byte[CB_BUSY_N] = 1'b0; cond_byte[CB_ACK] = 1'b1; end
            HS_ACK_LOW: begin cond_byte[CB_BUSY_N] = 1'b0; cond_byte[CB_ACK] = 1'b0; end
            default:    begin cond_byte[CB_BUSY_N] = 1'b1; cond_byte[CB_ACK] = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_data <= data_q;
        end
    end

    AST_INIT_READY: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> cond_byte == COND_READY) else $error("init did not restore"); // R4
    AST_BUSY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        accept_wr |=> !cond_byte[CB_BUSY_N]) else $error("busy not cleared"); // R5
    AST_BUSY_IMPLIES_ACK: assert property (@(posedge clk) disable iff (rst)
        cond_byte[CB_BUSY_N] |-> cond_byte[CB_ACK]) else $error("busy without ack"); // R9
    AST_NO_STEP_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        (ev.cond_rd && old_strobe) |=> $stable(cond_byte)) else $error("stepped with strobe high"); // R9
endmodule

// File: rtl/lpt_irq_ctrl.sv
module lpt_irq_ctrl
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              old_irq_en,
    output logic              irq
);
    logic pend_q, raise;

    assign raise = ev.cmd_wr && bus_wdata[CM_INIT_N] && bus_wdata[CM_SELECT]
                   && !bus_wdata[CM_STROBE] && old_irq_en;

    always_ff @(posedge clk) begin
        if (rst)             pend_q <= 1'b0;
        else if (ev.cond_rd) pend_q <= 1'b0;
        else if (raise)      pend_q <= 1'b1;
    end

    assign irq = pend_q;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ev.cond_rd |=> !irq) else $error("irq survived condition read"); // R8
    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(old_irq_en)) else $error("irq raised without old enable"); // R7
endmodule

// File: rtl/lpt_printer_port.sv
module lpt_printer_port
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              irq
);
    bus_ev_t           ev;
    logic [BYTE_W-1:0] data_q, cmd_q, cond_byte;

    lpt_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .data_q   (data_q),
        .cond_byte(cond_byte),
        .cmd_q    (cmd_q),
        .ev       (ev),
        .bus_rdata(bus_rdata)
    );

    lpt_host_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .bus_wdata(bus_wdata),
        .data_q   (data_q),
        .cmd_q    (cmd_q)
    );

    lpt_printer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .bus_wdata (bus_wdata),
        .old_strobe(cmd_q[CM_STROBE]),
        .data_q    (data_q),
        .cond_byte (cond_byte),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    lpt_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .bus_wdata (bus_wdata),
        .old_irq_en(cmd_q[CM_IRQ_EN]),
        .irq       (irq)
    );

    AST_EMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid) else $error("emit pulse longer than one cycle"); // R6
    AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(bus_wr && bus_addr[2:0] == 3'd2 && bus_wdata[0]
                            && bus_wdata[3] && bus_wdata[2]))
        else $error("emit without strobe write"); // R6
    AST_EMIT_DATA: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data == $past(data_q)) else $error("emitted wrong byte"); // R6
endmodule

// File: tb/lpt_printer_port_bench.sv
module lpt_printer_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        irq;

    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    lpt_printer_port #(.ADDR_W(16)) u_lpt_printer_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_valid(out_valid),
        .out_data(out_data), .irq(irq)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check8(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: strobe write expected to emit pushes the byte into the scoreboard
    task automatic wr_emit(input logic [7:0] v, input logic [7:0] byte_exp);
        exp_q.push_back(byte_exp);
        wr(16'h0002, v);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        check8(tag, {7'd0, irq}, {7'd0, exp});
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R6 unexpected emit actual=%02h expected=none", out_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (out_data !== e) begin
                    failures++;
                    $display("FAIL R6 emitted byte actual=%02h expected=%02h", out_data, e);
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd(16'h0000, 8'h00, "R1 data");
        rd(16'h0001, 8'hD8, "R1 cond");
        rd(16'h0002, 8'h0C, "R1 cmd");
        check_irq(1'b0, "R1 irq");
        check8("R1 out_valid", {7'd0, out_valid}, 8'h00);
        rd(16'h0003, 8'hFF, "R2 open offset 3");
        rd(16'h0006, 8'hFF, "R2 open offset 6");
        // R3 data store
        wr(16'h0000, 8'h41);
        rd(16'h0000, 8'h41, "R3 data read");
        rd(16'h0002, 8'h0C, "R3 cmd read");
        rd(16'h0001, 8'hD8, "R3 no side effect");
        // R2 aliasing and ignored writes
        rd(16'h0008, 8'h41, "R2 alias data");
        wr(16'h000F, 8'h55);
        wr(16'h0001, 8'h00);
        rd(16'h0000, 8'h41, "R2 ignored write data");
        rd(16'h0002, 8'h0C, "R2 ignored write cmd");
        rd(16'h0001, 8'hD8, "R2 ignored write cond");
        // R5/R6 accept and emit
        wr_emit(8'h0D, 8'h41);
        rd(16'h0001, 8'h58, "R5 busy cleared");
        rd(16'h0001, 8'h58, "R9 no step with strobe high");
        wr(16'h0002, 8'h0C);
        check_irq(1'b0, "R7 old enable clear");
        // R9 sequence
        rd(16'h0001, 8'h58, "R9 read before drop");
        rd(16'h0001, 8'h18, "R9 ack dropped");
        rd(16'h0001, 8'hD8, "R9 release");
        rd(16'h0000, 8'h41, "R9 data read no step");
        rd(16'h0001, 8'hD8, "R9 ready stays");
        // R6 stored strobe gating
        wr(16'h0000, 8'h5A);
        wr_emit(8'h0D, 8'h5A);
        wr(16'h0002, 8'h0D);
        rd(16'h0001, 8'h58, "R6 re-strobe no emit");
        // R7 interrupt uses old enable
        wr(16'h0002, 8'h1C);
        check_irq(1'b0, "R7 new enable ignored");
        wr(16'h0002, 8'h1C);
        check_irq(1'b1, "R7 raise");
        wr(16'h0000, 8'h77);
        check_irq(1'b1, "R3 data write keeps irq");
        rd(16'h0002, 8'h1C, "R3 cmd read");
        check_irq(1'b1, "R3 cmd read keeps irq");
        rd(16'h0001, 8'h58, "R8 returns old byte");
        check_irq(1'b0, "R8 irq cleared");
        rd(16'h0001, 8'h18, "R9 ack dropped again");
        rd(16'h0001, 8'hD8, "R9 release again");
        wr(16'h0002, 8'h0C);
        check_irq(1'b1, "R7 old enable set new clear");
        rd(16'h0001, 8'hD8, "R8 read in ready");
        check_irq(1'b0, "R8 irq cleared again");
        // R10 select low
        wr(16'h0000, 8'h33);
        wr(16'h0002, 8'h05);
        rd(16'h0001, 8'hD8, "R10 cond unchanged");
        check_irq(1'b0, "R10 no irq");
        wr(16'h0002, 8'h0D);
        rd(16'h0001, 8'h58, "R6 busy cleared no emit after old strobe");
        wr(16'h0002, 8'h0C);
        wr_emit(8'h0D, 8'h33);
        // R4 init
        wr(16'h0002, 8'h08);
        rd(16'h0001, 8'hD8, "R4 init restores");
        wr(16'h0002, 8'h09);
        rd(16'h0001, 8'hD8, "R4 init with strobe");
        // R1 reset mid-run
        wr(16'h0002, 8'h1C);
        wr(16'h0002, 8'h1C);
        check_irq(1'b1, "R7 raise before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_irq(1'b0, "R1 irq after reset");
        rd(16'h0002, 8'h0C, "R1 cmd after reset");
        rd(16'h0000, 8'h00, "R1 data after reset");
        rd(16'h0001, 8'hD8, "R1 cond after reset");
        repeat (4) @(negedge clk);
        check8("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        summary();
    end
endmodule